// File: doc/BRIEF.md
# Sliding Ray Attack Generator

This unit computes, for one square of an 8x8 board held as a 64-bit word, every square a sliding piece standing there could reach. Square index `rank*8 + file` selects bit positions, so bit 0 is rank 0 file 0 and bit 63 is rank 7 file 7. Along each enabled direction the ray runs outward from the origin square and ends at the board edge or at the first occupied square, whichever comes first. An occupied square that ends a ray is included in the result.

Internally the occupancy is rotated so that the origin sits at bit 0. A fixed, square-independent shuffle then gathers the eight half-rays into the eight bytes of a word. Positions that fall off the board for this square are forced to one, and so is a stop bit at the top of every byte. A single 64-bit subtraction followed by an XOR then resolves the blockers on all rays at once. The inverse shuffle and a rotation back give the result. The result is registered, and it appears one clock after the request.

A two-bit selector chooses the orthogonal rays, the diagonal rays, both, or neither. This covers rook, bishop and queen style movement.

Top module: `ray_attack_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier, and `attacks` carries the result for the inputs presented on that earlier edge.
- R2: While `in_valid` is low, `attacks` keeps its previous value whatever the other inputs do.
- R3: While `rst_n` is low, `out_valid` and `attacks` are zero.
- R4: With `ray_sel` = 2'b11, `attacks` holds every square along the eight directions (east, west, north, south and the four diagonals). Each direction stops at and includes the first square whose occupancy bit is 1; squares beyond that blocker are not set.
- R5: Rays never wrap around the board. A square on file 7 has no east or diagonal-east squares, a square on rank 0 has no southward squares, and the same holds for every other edge.
- R6: `ray_sel` bit 0 enables the four orthogonal directions and bit 1 the four diagonal ones. With 2'b01 on an empty board the result has exactly 14 bits set. With 2'b00 the result is zero.
- R7: The origin square is never set in `attacks`, even when its occupancy bit is 1.
- R8: Occupancy bits on squares that lie on none of the origin's eight rays do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; captures a new result |
| occ | input | 64 | Board occupancy, bit rank*8+file |
| sq | input | 6 | Origin square index |
| ray_sel | input | 2 | Bit 0 orthogonal rays, bit 1 diagonal rays |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| attacks | output | 64 | Reachable squares, bit rank*8+file |

## Verification
The hardest case to reach is the one where a packed ray position draws on a rotated bit that has wrapped across the board edge. Some board bits, such as the corner diagonals, also feed two rays at once. Both only misbehave for particular squares combined with a blocker placed just past an edge. To reach them, the stimulus sweeps all 64 origin squares under every selector value. It uses empty, full and several pseudo-random occupancies, which puts blockers on the edge squares of every ray. Every result is compared against a direction-walking model of the board. The unit then reapplies the same square with all off-ray squares filled and expects an identical result.

// File: rtl/ray_attack_unit.sv
module ray_attack_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] occ,
  input  logic [5:0]  sq,
  input  logic [1:0]  ray_sel,
  output logic        out_valid,
  output logic [63:0] attacks
);
  localparam int NDIR = 8;
  localparam int RAYLEN = 7;
  localparam int STEP [NDIR] = '{1, -1, 8, -8, 9, -9, 7, -7};

  logic [127:0] dbl_in, dbl_out;
  logic [63:0]  rot, packed_w, edge_m, v, sub_k, ray_att, rel, res;
  int           lim [NDIR];
  int           rk, fl;

  assign dbl_in = {occ, occ} >> sq;
  assign rot    = dbl_in[63:0];

  always_comb begin
    rk = int'(sq[5:3]);
    fl = int'(sq[2:0]);
    lim[0] = 7 - fl;
    lim[1] = fl;
    lim[2] = 7 - rk;
    lim[3] = rk;
    lim[4] = (7 - rk) < (7 - fl) ? (7 - rk) : (7 - fl);
    lim[5] = rk < fl ? rk : fl;
    lim[6] = (7 - rk) < fl ? (7 - rk) : fl;
    lim[7] = rk < (7 - fl) ? rk : (7 - fl);
  end

  always_comb begin
    packed_w = '0;
    edge_m   = '0;
    sub_k    = '0;
    for (int d = 0; d < NDIR; d++) begin
      edge_m[6'(d*8 + 7)] = 1'b1;
      sub_k[6'(d*8)] = (d < 4) ? ray_sel[0] : ray_sel[1];
      for (int k = 1; k <= RAYLEN; k++) begin
        packed_w[6'(d*8 + k - 1)] = rot[6'((STEP[d] * k) & 63)];
        edge_m[6'(d*8 + k - 1)]   = (k > lim[d]);
      end
    end
  end

  assign v       = packed_w | edge_m;
  assign ray_att = (v ^ (v - sub_k)) & ~edge_m;

  always_comb begin
    rel = '0;
    for (int d = 0; d < NDIR; d++)
      for (int k = 1; k <= RAYLEN; k++)
        rel[6'((STEP[d] * k) & 63)] = rel[6'((STEP[d] * k) & 63)] | ray_att[6'(d*8 + k - 1)];
  end

  assign dbl_out = {rel, rel} << sq;
  assign res     = dbl_out[127:64];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      attacks   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) attacks <= res;
    end
  end
endmodule

// File: rtl/ray_attack_unit_chk.sv
module ray_attack_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] occ,
  input logic [5:0]  sq,
  input logic [1:0]  ray_sel,
  input logic        out_valid,
  input logic [63:0] attacks
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(attacks));

  p_rook_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && occ == 64'd0 && ray_sel == 2'b01) |=> $countones(attacks) == 14);

  p_none_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ray_sel == 2'b00) |=> attacks == 64'd0);

  p_no_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !attacks[$past(sq)]);

  p_full_board_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && occ == '1 && ray_sel == 2'b11) |=>
      ($countones(attacks) >= 3 && $countones(attacks) <= 8));
endmodule

bind ray_attack_unit ray_attack_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .occ(occ), .sq(sq),
  .ray_sel(ray_sel), .out_valid(out_valid), .attacks(attacks)
);

// File: tb/ray_attack_unit_bench.sv
module ray_attack_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] occ = '0;
  logic [5:0]  sq = '0;
  logic [1:0]  ray_sel = '0;
  logic        out_valid;
  logic [63:0] attacks;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ray_attack_unit u_ray_attack_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .occ(occ), .sq(sq),
    .ray_sel(ray_sel), .out_valid(out_valid), .attacks(attacks)
  );

  function automatic logic [63:0] model(input logic [63:0] o, input int s, input logic [1:0] m);
    int dr [8] = '{0, 0, 1, -1, 1, -1, 1, -1};
    int df [8] = '{1, -1, 0, 0, 1, -1, -1, 1};
    logic [63:0] r = '0;
    for (int d = 0; d < 8; d++) begin
      if ((d < 4) ? m[0] : m[1]) begin
        int y = s / 8 + dr[d];
        int x = s % 8 + df[d];
        bit go = 1;
        while (go && y >= 0 && y < 8 && x >= 0 && x < 8) begin
          r[y*8 + x] = 1'b1;
          if (o[y*8 + x]) go = 0;
          y += dr[d];
          x += df[d];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] mix(input logic [63:0] x);
    logic [63:0] y = x;
    y ^= y << 13;
    y ^= y >> 7;
    y ^= y << 17;
    return y;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] o, input logic [5:0] s, input logic [1:0] m);
    @(negedge clk);
    in_valid = 1'b1; occ = o; sq = s; ray_sel = m;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input logic [63:0] o, input logic [5:0] s, input logic [1:0] m);
    logic [63:0] e;
    e = model(o, int'(s), m);
    apply(o, s, m);
    check("R1 out_valid", {63'd0, out_valid}, 64'd1);
    if (m == 2'b00) check("R6 none selected", attacks, 64'd0);
    else if (m == 2'b11) check("R4 queen rays", attacks, e);
    else check("R6 partial rays", attacks, e);
    if (o[s]) check("R7 origin clear", {63'd0, attacks[s]}, 64'd0);
  endtask

  initial begin
    logic [63:0] seed;
    logic [63:0] pats [6];
    logic [63:0] prev;
    repeat (3) @(negedge clk);
    check("R3 reset valid", {63'd0, out_valid}, 64'd0);
    check("R3 reset attacks", attacks, 64'd0);
    rst_n = 1'b1;

    seed = 64'h9E3779B97F4A7C15;
    pats[0] = 64'd0;
    pats[1] = '1;
    for (int i = 2; i < 6; i++) begin
      seed = mix(seed);
      pats[i] = (i == 5) ? (seed & mix(seed)) : seed;
    end

    for (int p = 0; p < 6; p++)
      for (int s = 0; s < 64; s++)
        for (int m = 0; m < 4; m++)
          run_one(pats[p] | ((p == 4) ? (64'd1 << s) : 64'd0), 6'(s), 2'(m));

    for (int s = 0; s < 64; s++) begin
      logic [63:0] on_ray, base;
      on_ray = model(64'd0, s, 2'b11);
      seed = mix(seed);
      apply(seed, 6'(s), 2'b11);
      base = attacks;
      apply(seed | ~on_ray, 6'(s), 2'b11);
      check("R8 off-ray occupancy ignored", attacks, base);
    end

    for (int r = 0; r < 8; r++) begin
      apply(64'd0, 6'(r*8 + 7), 2'b11);
      if (r < 7) check("R5 no east wrap", {63'd0, attacks[r*8 + 8]}, 64'd0);
      check("R5 edge file 7", attacks & 64'h8080808080808080, model(64'd0, r*8+7, 2'b01) & 64'h8080808080808080);
    end
    apply(64'd0, 6'd0, 2'b01);
    check("R5 corner rook", attacks, 64'h01010101010101FE);

    apply(pats[3], 6'd27, 2'b11);
    prev = attacks;
    @(negedge clk);
    occ = '1; sq = 6'd5; ray_sel = 2'b01;
    @(negedge clk);
    check("R2 hold while idle", attacks, prev);
    check("R1 valid low", {63'd0, out_valid}, 64'd0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule